// File: doc/BRIEF.md
# Integer ALU and Shifter

This block is the execute stage for register-to-register integer operations of a 32-bit load/store processor. It takes a 6-bit function code, a 5-bit immediate shift count, a destination register index and the two source operand values (the first and second source register, called rs and rt below). It produces a 32-bit result, a write-enable for the destination register, a trapping-overflow flag and a reserved-instruction flag. Trap handling, the register file and the pipeline around the block are left to other logic. The block only raises the flags.

The datapath is combinational: a function decoder, a barrel shifter and a shared adder/subtractor that also serves the compares. A thin wrapper registers the outputs once, so every sampled operation shows its result one clock later, qualified by `out_valid_o`. The two 64-bit doubleword operation families are not executed. Their function codes are reported as reserved, and so is every other code that is not listed below.

Top module: `alu_exec_top`

## Requirements
- R1: After reset `out_valid_o`, `wr_en_o`, `ovf_trap_o` and `rsvd_instr_o` are 0. An operation sampled with `in_valid_i` high shows its outputs with `out_valid_o` high exactly one clock later. With `out_valid_o` low the three flags are 0.
- R2: Immediate shifts move rt by `shamt_i`. The codes are 0x00 (left logical), 0x02 (right logical) and 0x03 (right arithmetic). The logical shifts fill vacated bits with 0.
- R3: The right arithmetic shifts (0x03 and 0x07) fill vacated upper bits with copies of rt bit 31.
- R4: Variable shifts take their count from rs[4:0] only, and rs[31:5] has no effect. The codes are 0x04 (left logical), 0x06 (right logical, zero fill) and 0x07 (right arithmetic). The result is never sign-extended except by the arithmetic variant.
- R5: Code 0x20 (signed add) writes rs+rt modulo 2^32 and raises `ovf_trap_o` when both operands share a sign and the sum's sign differs. Code 0x21 (unsigned add) writes the same sum and never raises `ovf_trap_o`.
- R6: Code 0x22 (signed subtract) writes rs-rt modulo 2^32 and raises `ovf_trap_o` when the true signed difference does not fit in 32 bits. Code 0x23 (unsigned subtract) writes the same difference and never raises `ovf_trap_o`.
- R7: Code 0x2A writes 1 if rs < rt as signed numbers, otherwise 0. Code 0x2B does the same with an unsigned compare.
- R8: The bitwise codes are 0x24 (AND), 0x25 (OR), 0x26 (XOR) and 0x27 (NOR, which gives ~(rs|rt)).
- R9: Any function code not listed in R2 to R8 raises `rsvd_instr_o` and gives `wr_en_o`=0 and a result of 0. This includes the doubleword codes 0x14, 0x16, 0x17, 0x2C to 0x2F, 0x38, 0x3A, 0x3B, 0x3C, 0x3E and 0x3F.
- R10: While `ovf_trap_o` is high, `wr_en_o` is 0. The result still carries the wrapped value.
- R11: A destination index of 0 forces `wr_en_o` to 0 for every operation. The result and the flags are unaffected.
- R12: Operations issued on consecutive cycles each produce their own result on the cycle after their own issue, in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Operation present on the inputs this cycle |
| func_i | input | 6 | Function code |
| shamt_i | input | 5 | Immediate shift count |
| rd_idx_i | input | 5 | Destination register index |
| rs_val_i | input | 32 | First source operand (rs) |
| rt_val_i | input | 32 | Second source operand (rt) |
| out_valid_o | output | 1 | Outputs below belong to the operation issued one cycle earlier |
| result_o | output | 32 | Operation result |
| wr_en_o | output | 1 | Destination register write-enable |
| ovf_trap_o | output | 1 | Signed add/subtract overflow trap request |
| rsvd_instr_o | output | 1 | Reserved-instruction request |

## Verification
Every result, write-enable and flag is due exactly one clock after the cycle in which its operation was presented with `in_valid_i` high, because a single output register stage follows the combinational datapath. The driver applies stimulus on the falling edge and queues a reference item computed with 64-bit integer arithmetic. The monitor samples on each later falling edge and pops one item whenever `out_valid_o` is high, so every comparison lands on the cycle its operation is due. Back-to-back issue checks that one-cycle spacing holds for every item in the queue, and idle gaps check that nothing appears without an issue.

// File: rtl/alu_exec_pkg.sv
package alu_exec_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [5:0] {
    FN_SLL  = 6'h00,
    FN_SRL  = 6'h02,
    FN_SRA  = 6'h03,
    FN_SLLV = 6'h04,
    FN_SRLV = 6'h06,
    FN_SRAV = 6'h07,
    FN_ADD  = 6'h20,
    FN_ADDU = 6'h21,
    FN_SUB  = 6'h22,
    FN_SUBU = 6'h23,
    FN_AND  = 6'h24,
    FN_OR   = 6'h25,
    FN_XOR  = 6'h26,
    FN_NOR  = 6'h27,
    FN_SLT  = 6'h2A,
    FN_SLTU = 6'h2B
  } fn_code_e;

  typedef enum logic [2:0] {
    GRP_NONE,
    GRP_SHIFT,
    GRP_ARITH,
    GRP_CMP,
    GRP_LOGIC
  } op_grp_e;

  typedef enum logic [1:0] {
    LG_AND,
    LG_OR,
    LG_XOR,
    LG_NOR
  } logic_op_e;

  typedef struct packed {
    op_grp_e   grp;
    logic      sh_var;
    logic      sh_left;
    logic      sh_arith;
    logic      sub;
    logic      trap_ovf;
    logic      cmp_uns;
    logic_op_e lg;
  } alu_ctrl_t;

  // Two's complement overflow from operand and result sign bits.
  function automatic logic f_signed_ovf(input logic a_msb, input logic b_msb,
                                        input logic r_msb, input logic sub);
    logic b_eff;
    b_eff = b_msb ^ sub;
    return (a_msb == b_eff) && (r_msb != a_msb);
  endfunction

  // Signed less-than from the difference sign and the overflow bit.
  function automatic logic f_signed_lt(input logic diff_msb, input logic ovf);
    return diff_msb ^ ovf;
  endfunction

endpackage

// File: rtl/alu_func_decode.sv
module alu_func_decode
  import alu_exec_pkg::*;
(
  input  logic [5:0] func_i,
  output alu_ctrl_t  ctrl_o,
  output logic       legal_o
);

  always_comb begin
    ctrl_o   = '{grp: GRP_NONE, sh_var: 1'b0, sh_left: 1'b0, sh_arith: 1'b0,
                 sub: 1'b0, trap_ovf: 1'b0, cmp_uns: 1'b0, lg: LG_AND};
    legal_o  = 1'b1;
    case (func_i)
      FN_SLL:  begin ctrl_o.grp = GRP_SHIFT; ctrl_o.sh_left = 1'b1; end
      FN_SRL:  begin ctrl_o.grp = GRP_SHIFT; end
      FN_SRA:  begin ctrl_o.grp = GRP_SHIFT; ctrl_o.sh_arith = 1'b1; end
      FN_SLLV: begin ctrl_o.grp = GRP_SHIFT; ctrl_o.sh_var = 1'b1; ctrl_o.sh_left = 1'b1; end
      FN_SRLV: begin ctrl_o.grp = GRP_SHIFT; ctrl_o.sh_var = 1'b1; end
      FN_SRAV: begin ctrl_o.grp = GRP_SHIFT; ctrl_o.sh_var = 1'b1; ctrl_o.sh_arith = 1'b1; end
      FN_ADD:  begin ctrl_o.grp = GRP_ARITH; ctrl_o.trap_ovf = 1'b1; end
      FN_ADDU: begin ctrl_o.grp = GRP_ARITH; end
      FN_SUB:  begin ctrl_o.grp = GRP_ARITH; ctrl_o.sub = 1'b1; ctrl_o.trap_ovf = 1'b1; end
      FN_SUBU: begin ctrl_o.grp = GRP_ARITH; ctrl_o.sub = 1'b1; end
      FN_AND:  begin ctrl_o.grp = GRP_LOGIC; ctrl_o.lg = LG_AND; end
      FN_OR:   begin ctrl_o.grp = GRP_LOGIC; ctrl_o.lg = LG_OR; end
      FN_XOR:  begin ctrl_o.grp = GRP_LOGIC; ctrl_o.lg = LG_XOR; end
      FN_NOR:  begin ctrl_o.grp = GRP_LOGIC; ctrl_o.lg = LG_NOR; end
      FN_SLT:  begin ctrl_o.grp = GRP_CMP; ctrl_o.sub = 1'b1; end
      FN_SLTU: begin ctrl_o.grp = GRP_CMP; ctrl_o.sub = 1'b1; ctrl_o.cmp_uns = 1'b1; end
      default: legal_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_shift_unit.sv
module alu_shift_unit #(
  parameter int DATA_W = alu_exec_pkg::WORD_W,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] value_i,
  input  logic [SH_W-1:0]   amt_i,
  input  logic              left_i,
  input  logic              arith_i,
  output logic [DATA_W-1:0] shifted_o
);

  logic              fill_bit;
  logic [DATA_W-1:0] stage [0:SH_W];
  logic [DATA_W-1:0] pre_rev;
  logic [DATA_W-1:0] post_rev;

  // Left shifts run through the right shifter on bit-reversed data.
  assign fill_bit = arith_i & ~left_i & value_i[DATA_W-1];

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      pre_rev[i]  = value_i[DATA_W-1-i];
      post_rev[i] = stage[SH_W][DATA_W-1-i];
    end
  end

  assign stage[0] = left_i ? pre_rev : value_i;

  for (genvar g = 0; g < SH_W; g++) begin : g_stage
    localparam int STEP = 1 << g;
    assign stage[g+1] = amt_i[g] ? {{STEP{fill_bit}}, stage[g][DATA_W-1:STEP]}
                                 : stage[g];
  end

  assign shifted_o = left_i ? post_rev : stage[SH_W];

endmodule

// File: rtl/alu_addsub_unit.sv
module alu_addsub_unit
  import alu_exec_pkg::*;
#(
  parameter int DATA_W = alu_exec_pkg::WORD_W
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              ovf_o,
  output logic              lt_signed_o,
  output logic              lt_unsigned_o
);

  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   wide_sum;

  assign b_eff    = sub_i ? ~b_i : b_i;
  assign wide_sum = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub_i};
  assign sum_o    = wide_sum[DATA_W-1:0];

  assign ovf_o         = f_signed_ovf(a_i[DATA_W-1], b_i[DATA_W-1],
                                      sum_o[DATA_W-1], sub_i);
  assign lt_signed_o   = f_signed_lt(sum_o[DATA_W-1], ovf_o);
  // In subtract mode a missing carry out means a borrow: a < b unsigned.
  assign lt_unsigned_o = ~wide_sum[DATA_W];

endmodule

// File: rtl/alu_exec_top.sv
module alu_exec_top
  import alu_exec_pkg::*;
#(
  parameter int DATA_W  = alu_exec_pkg::WORD_W,
  parameter int FUNC_W  = 6,
  parameter int REG_W   = 5,
  localparam int SH_W   = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [FUNC_W-1:0] func_i,
  input  logic [SH_W-1:0]   shamt_i,
  input  logic [REG_W-1:0]  rd_idx_i,
  input  logic [DATA_W-1:0] rs_val_i,
  input  logic [DATA_W-1:0] rt_val_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              wr_en_o,
  output logic              ovf_trap_o,
  output logic              rsvd_instr_o
);

  alu_ctrl_t         ctrl;
  logic              legal;
  logic [SH_W-1:0]   sh_amt;
  logic [DATA_W-1:0] sh_res;
  logic [DATA_W-1:0] as_sum;
  logic              as_ovf;
  logic              as_lt_s;
  logic              as_lt_u;
  logic [DATA_W-1:0] lg_res;

  // Named internal events, visible to the checker.
  logic [DATA_W-1:0] core_result;
  logic              core_ovf;
  logic              core_rsvd;
  logic              core_wr;
  logic              dest_is_zero;

  alu_func_decode u_dec (
    .func_i  (func_i),
    .ctrl_o  (ctrl),
    .legal_o (legal)
  );

  assign sh_amt = ctrl.sh_var ? rs_val_i[SH_W-1:0] : shamt_i;

  alu_shift_unit #(.DATA_W(DATA_W)) u_shift (
    .value_i   (rt_val_i),
    .amt_i     (sh_amt),
    .left_i    (ctrl.sh_left),
    .arith_i   (ctrl.sh_arith),
    .shifted_o (sh_res)
  );

  alu_addsub_unit #(.DATA_W(DATA_W)) u_addsub (
    .a_i           (rs_val_i),
    .b_i           (rt_val_i),
    .sub_i         (ctrl.sub),
    .sum_o         (as_sum),
    .ovf_o         (as_ovf),
    .lt_signed_o   (as_lt_s),
    .lt_unsigned_o (as_lt_u)
  );

  always_comb begin
    case (ctrl.lg)
      LG_AND:  lg_res = rs_val_i & rt_val_i;
      LG_OR:   lg_res = rs_val_i | rt_val_i;
      LG_XOR:  lg_res = rs_val_i ^ rt_val_i;
      default: lg_res = ~(rs_val_i | rt_val_i);
    endcase
  end

  always_comb begin
    case (ctrl.grp)
      GRP_SHIFT: core_result = sh_res;
      GRP_ARITH: core_result = as_sum;
      GRP_LOGIC: core_result = lg_res;
      GRP_CMP:   core_result = {{(DATA_W-1){1'b0}}, ctrl.cmp_uns ? as_lt_u : as_lt_s};
      default:   core_result = '0;
    endcase
  end

  assign core_ovf     = legal && ctrl.grp == GRP_ARITH && ctrl.trap_ovf && as_ovf;
  assign core_rsvd    = ~legal;
  assign dest_is_zero = (rd_idx_i == '0);
  assign core_wr      = legal && !core_ovf && !dest_is_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o  <= 1'b0;
      result_o     <= '0;
      wr_en_o      <= 1'b0;
      ovf_trap_o   <= 1'b0;
      rsvd_instr_o <= 1'b0;
    end else begin
      out_valid_o  <= in_valid_i;
      result_o     <= in_valid_i ? core_result : '0;
      wr_en_o      <= in_valid_i && core_wr;
      ovf_trap_o   <= in_valid_i && core_ovf;
      rsvd_instr_o <= in_valid_i && core_rsvd;
    end
  end

endmodule

// File: rtl/alu_exec_chk.sv
module alu_exec_chk #(
  parameter int DATA_W = 32,
  parameter int FUNC_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic [FUNC_W-1:0] func_i,
  input logic              dest_is_zero,
  input logic              out_valid_o,
  input logic [DATA_W-1:0] result_o,
  input logic              wr_en_o,
  input logic              ovf_trap_o,
  input logic              rsvd_instr_o
);

  a_r1_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> (!wr_en_o && !ovf_trap_o && !rsvd_instr_o));

  a_r9_rsvd_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsvd_instr_o |-> (!wr_en_o && result_o == '0 && !ovf_trap_o));

  a_r10_ovf_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_trap_o |-> !wr_en_o);

  a_r11_zero_dest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && dest_is_zero) |=> !wr_en_o);

  a_r5_unsigned_no_trap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && (func_i == 6'h21 || func_i == 6'h23)) |=> !ovf_trap_o);

  a_r7_cmp_boolean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && (func_i == 6'h2A || func_i == 6'h2B)) |=> (result_o[DATA_W-1:1] == '0));

endmodule

bind alu_exec_top alu_exec_chk #(.DATA_W(DATA_W), .FUNC_W(FUNC_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .in_valid_i   (in_valid_i),
  .func_i       (func_i),
  .dest_is_zero (dest_is_zero),
  .out_valid_o  (out_valid_o),
  .result_o     (result_o),
  .wr_en_o      (wr_en_o),
  .ovf_trap_o   (ovf_trap_o),
  .rsvd_instr_o (rsvd_instr_o)
);

// File: tb/alu_exec_top_tb.sv
`timescale 1ns/1ps
module alu_exec_top_tb;

  typedef struct {
    logic [31:0] result;
    logic        wr;
    logic        ovf;
    logic        rsvd;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [5:0]  func = '0;
  logic [4:0]  shamt = '0;
  logic [4:0]  rd_idx = '0;
  logic [31:0] rs_val = '0;
  logic [31:0] rt_val = '0;
  logic        out_valid;
  logic [31:0] result;
  logic        wr_en;
  logic        ovf_trap;
  logic        rsvd_instr;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  alu_exec_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .func_i(func),
    .shamt_i(shamt), .rd_idx_i(rd_idx), .rs_val_i(rs_val), .rt_val_i(rt_val),
    .out_valid_o(out_valid), .result_o(result), .wr_en_o(wr_en),
    .ovf_trap_o(ovf_trap), .rsvd_instr_o(rsvd_instr)
  );

  // Reference model built on 64-bit integers.
  function automatic exp_t model(input logic [5:0] f, input logic [4:0] sa,
                                 input logic [4:0] rd, input logic [31:0] a,
                                 input logic [31:0] b, input string tag);
    exp_t e;
    longint sa_s, sb_s, wide;
    logic [63:0] ext;
    int n;
    logic ok;
    sa_s = longint'($signed(a));
    sb_s = longint'($signed(b));
    e.result = '0; e.ovf = 0; e.rsvd = 0; e.tag = tag; ok = 1;
    n = (f == 6'h04 || f == 6'h06 || f == 6'h07) ? int'(a[4:0]) : int'(sa);
    case (f)
      6'h00, 6'h04: e.result = b << n;
      6'h02, 6'h06: e.result = b >> n;
      6'h03, 6'h07: begin ext = {{32{b[31]}}, b}; ext = ext >> n; e.result = ext[31:0]; end
      6'h20, 6'h21: begin
        wide = sa_s + sb_s; e.result = a + b;
        e.ovf = (f == 6'h20) && (wide > 64'sd2147483647 || wide < -64'sd2147483648);
      end
      6'h22, 6'h23: begin
        wide = sa_s - sb_s; e.result = a - b;
        e.ovf = (f == 6'h22) && (wide > 64'sd2147483647 || wide < -64'sd2147483648);
      end
      6'h24: e.result = a & b;
      6'h25: e.result = a | b;
      6'h26: e.result = a ^ b;
      6'h27: e.result = ~(a | b);
      6'h2A: e.result = (sa_s < sb_s) ? 32'd1 : 32'd0;
      6'h2B: e.result = ({32'd0, a} < {32'd0, b}) ? 32'd1 : 32'd0;
      default: begin ok = 0; e.rsvd = 1; end
    endcase
    e.wr = ok && !e.ovf && (rd != 0);
    return e;
  endfunction

  task automatic issue(input logic [5:0] f, input logic [4:0] sa, input logic [4:0] rd,
                       input logic [31:0] a, input logic [31:0] b, input string tag);
    @(negedge clk);
    in_valid = 1; func = f; shamt = sa; rd_idx = rd; rs_val = a; rt_val = b;
    sb_q.push_back(model(f, sa, rd, a, b, tag));
  endtask

  task automatic idle(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      in_valid = 0;
    end
  endtask

  // Monitor: outputs are due one cycle after issue; sampled on the falling edge.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      exp_t e;
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL R1: out_valid with no issued operation (actual 1, expected 0)");
      end else begin
        e = sb_q.pop_front();
        if (result !== e.result || wr_en !== e.wr || ovf_trap !== e.ovf || rsvd_instr !== e.rsvd) begin
          errors++;
          $display("FAIL %s: actual res=%h wr=%b ovf=%b rsvd=%b expected res=%h wr=%b ovf=%b rsvd=%b",
                   e.tag, result, wr_en, ovf_trap, rsvd_instr, e.result, e.wr, e.ovf, e.rsvd);
        end
      end
    end else if (rst_n && !out_valid) begin
      if (wr_en !== 0 || ovf_trap !== 0 || rsvd_instr !== 0) begin
        checks++; errors++;
        $display("FAIL R1: flags while idle actual wr=%b ovf=%b rsvd=%b expected 0 0 0",
                 wr_en, ovf_trap, rsvd_instr);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 0 || wr_en !== 0 || ovf_trap !== 0 || rsvd_instr !== 0) begin
      errors++;
      $display("FAIL R1: reset state actual v=%b wr=%b ovf=%b rsvd=%b expected all 0",
               out_valid, wr_en, ovf_trap, rsvd_instr);
    end
    rst_n = 1;
    idle(2);

    // R2 immediate shifts
    issue(6'h00, 5'd4,  5'd3, 32'h0, 32'h8000_00F1, "R2");
    issue(6'h02, 5'd8,  5'd3, 32'h0, 32'hF000_1234, "R2");
    issue(6'h02, 5'd0,  5'd3, 32'h0, 32'hDEAD_BEEF, "R2");
    issue(6'h00, 5'd31, 5'd3, 32'h0, 32'h0000_0003, "R2");
    // R3 arithmetic right
    issue(6'h03, 5'd4,  5'd5, 32'h0, 32'h8000_0010, "R3");
    issue(6'h03, 5'd31, 5'd5, 32'h0, 32'h8000_0000, "R3");
    issue(6'h03, 5'd4,  5'd5, 32'h0, 32'h7000_0010, "R3");
    // R4 variable shifts, upper rs bits set
    issue(6'h04, 5'd9,  5'd6, 32'hFFFF_FFE3, 32'h0000_0001, "R4");
    issue(6'h06, 5'd0,  5'd6, 32'h1234_5610, 32'h8000_0000, "R4");
    issue(6'h07, 5'd0,  5'd6, 32'hABCD_EF08, 32'h8000_0000, "R4");
    issue(6'h06, 5'd31, 5'd6, 32'hFFFF_FFE0, 32'h8765_4321, "R4");
    idle(1);
    // R5 add
    issue(6'h20, 5'd0, 5'd7, 32'h7FFF_FFFF, 32'h0000_0001, "R5");
    issue(6'h20, 5'd0, 5'd7, 32'h8000_0000, 32'h8000_0000, "R5");
    issue(6'h20, 5'd0, 5'd7, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "R5");
    issue(6'h21, 5'd0, 5'd7, 32'h7FFF_FFFF, 32'h0000_0001, "R5");
    issue(6'h21, 5'd0, 5'd7, 32'hFFFF_FFFF, 32'h0000_0002, "R5");
    // R6 subtract
    issue(6'h22, 5'd0, 5'd8, 32'h8000_0000, 32'h0000_0001, "R6");
    issue(6'h22, 5'd0, 5'd8, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "R6");
    issue(6'h22, 5'd0, 5'd8, 32'h0000_0005, 32'h0000_0009, "R6");
    issue(6'h23, 5'd0, 5'd8, 32'h8000_0000, 32'h0000_0001, "R6");
    // R7 compares
    issue(6'h2A, 5'd0, 5'd9, 32'hFFFF_FFFF, 32'h0000_0001, "R7");
    issue(6'h2B, 5'd0, 5'd9, 32'hFFFF_FFFF, 32'h0000_0001, "R7");
    issue(6'h2A, 5'd0, 5'd9, 32'h8000_0000, 32'h7FFF_FFFF, "R7");
    issue(6'h2A, 5'd0, 5'd9, 32'h0000_0004, 32'h0000_0004, "R7");
    issue(6'h2B, 5'd0, 5'd9, 32'h0000_0003, 32'h8000_0000, "R7");
    // R8 bitwise
    issue(6'h24, 5'd0, 5'd10, 32'hF0F0_FF00, 32'h3C3C_0FF0, "R8");
    issue(6'h25, 5'd0, 5'd10, 32'hF0F0_FF00, 32'h3C3C_0FF0, "R8");
    issue(6'h26, 5'd0, 5'd10, 32'hF0F0_FF00, 32'h3C3C_0FF0, "R8");
    issue(6'h27, 5'd0, 5'd10, 32'hF0F0_FF00, 32'h3C3C_0FF0, "R8");
    idle(2);
    // R9 reserved codes
    issue(6'h2C, 5'd0, 5'd11, 32'h1, 32'h2, "R9");
    issue(6'h14, 5'd3, 5'd11, 32'h1, 32'h2, "R9");
    issue(6'h3F, 5'd3, 5'd11, 32'h1, 32'h2, "R9");
    issue(6'h01, 5'd3, 5'd11, 32'h1, 32'h2, "R9");
    issue(6'h18, 5'd0, 5'd11, 32'h1, 32'h2, "R9");
    // R10 overflow blocks write (rd nonzero)
    issue(6'h20, 5'd0, 5'd31, 32'h4000_0000, 32'h4000_0000, "R10");
    // R11 zero destination
    issue(6'h21, 5'd0, 5'd0, 32'h0000_0010, 32'h0000_0020, "R11");
    issue(6'h27, 5'd0, 5'd0, 32'h0, 32'h0, "R11");
    issue(6'h22, 5'd0, 5'd0, 32'h8000_0000, 32'h0000_0001, "R11");
    // R12 back-to-back sequence
    for (int k = 0; k < 20; k++) begin
      logic [31:0] a, b;
      logic [5:0] fsel;
      a = 32'h9E37_79B9 * (k + 1);
      b = 32'h7F4A_7C15 ^ (a << 3);
      case (k % 6)
        0: fsel = 6'h20; 1: fsel = 6'h07; 2: fsel = 6'h2A;
        3: fsel = 6'h26; 4: fsel = 6'h23; default: fsel = 6'h03;
      endcase
      issue(fsel, 5'(k), 5'(k % 4), a, b, "R12");
    end
    idle(4);
    checks++;
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL R12: pending items actual %0d expected 0", sb_q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule